// File: doc/BRIEF.md
# Three-Wire Codec Control Word Serializer

This block writes one control word into an audio codec's register file over three output lines: a serial data line, a serial clock and a load strobe. A controller pulses `start` with a 7-bit register address and a 9-bit value. The block joins them into a 16-bit word and shifts it out most significant bit first, one bit per clock period. It then raises the load strobe so the codec latches the word.

Each line level is held for a fixed number of system clock cycles, set by `HOLD_CYCLES`. With the default of 50 at a 50 MHz system clock, each level lasts 1 us. `busy` stays high for the whole frame. A single-cycle `done` pulse marks the return to idle. In idle, data and clock rest high and the load strobe stays high. The load strobe only goes low again when the next frame starts.

Top module: `codec_word_tx`

## Requirements
- R1: The word sent is {address, value}: address bits 6..0 land in word bits 15..9 and value bits 8..0 land in word bits 8..0. Bits go out word bit 15 first, and each one is valid on `sdata` at the rising edge of `sclk`.
- R2: One frame has exactly 16 rising edges of `sclk`.
- R3: In the cycle after a start is accepted, `busy` is 1 and `sdata`, `sclk` and `sload` are all 0.
- R4: The three lines start at 0, and the first `sclk` rise comes 2*HOLD_CYCLES cycles later. After that, every low and every high phase of `sclk` lasts exactly HOLD_CYCLES cycles. `sdata` changes only while `sclk` is low.
- R5: `sload` rises HOLD_CYCLES cycles after the 16th `sclk` rise, while `sclk` is still high.
- R6: HOLD_CYCLES cycles after `sload` rises, `sdata` and `sclk` are 1, `busy` is 0 and `done` is 1 for exactly one cycle. This happens 34*HOLD_CYCLES cycles after the lines first went low. `sdata`, `sclk` and `sload` then stay high while idle.
- R7: A start pulse while `busy` is 1 is ignored. It does not restart the frame and does not change the word or the frame timing.
- R8: After reset, `busy` and `done` are 0, `sdata` and `sclk` are 1, and `sload` is 0.
- R9: When a new frame is accepted, `sload` goes back to 0 in the same cycle as `sdata` and `sclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one frame; accepted only when not busy |
| reg_addr | input | 7 | Codec register address, captured on accept |
| reg_val | input | 9 | Register value, captured on accept |
| busy | output | 1 | High while a frame is in progress |
| done | output | 1 | One-cycle pulse when the frame ends |
| sdata | output | 1 | Serial data line |
| sclk | output | 1 | Serial clock line |
| sload | output | 1 | Load strobe |

## Verification
The bench uses the all-zero and all-one words, and alternating patterns, so that a swapped address/value split or a reversed bit order shows up in the captured word. It measures every `sclk` phase and the position of the load and done events against HOLD_CYCLES. This catches a design that drops or adds an interval, sends 15 or 17 bits, or raises load while the clock is low. It pulses start with different operands in the middle of a frame. A design that reloads on that pulse sends a corrupted word or finishes late. After each frame it checks that the lines stay high with load high until the next accept, and that load falls together with data and clock when the next frame starts.

// File: rtl/codec_word_tx.sv
module codec_word_tx #(
  parameter int HOLD_CYCLES = 50,
  parameter int ADDR_W      = 7,
  parameter int VAL_W       = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [VAL_W-1:0]  reg_val,
  output logic              busy,
  output logic              done,
  output logic              sdata,
  output logic              sclk,
  output logic              sload
);
  localparam int FW = ADDR_W + VAL_W;
  localparam int TW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam int BW = $clog2(FW);
  localparam logic [TW-1:0] TICK_LAST = TW'(HOLD_CYCLES - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(FW - 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LO, S_HI, S_LOAD} state_t;

  state_t        st;
  logic [TW-1:0] tick;
  logic [BW-1:0] nbit;
  logic [FW-1:0] shreg;
  logic          tick_end;

  assign tick_end = (tick == TICK_LAST);
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tick  <= '0;
      nbit  <= '0;
      shreg <= '0;
      sdata <= 1'b1;
      sclk  <= 1'b1;
      sload <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == S_IDLE) begin
        if (start) begin
          st    <= S_PRE;
          tick  <= '0;
          shreg <= {reg_addr, reg_val};
          sdata <= 1'b0;
          sclk  <= 1'b0;
          sload <= 1'b0;
        end
      end else if (!tick_end) begin
        tick <= tick + 1'b1;
      end else begin
        tick <= '0;
        case (st)
          S_PRE: begin
            st    <= S_LO;
            nbit  <= '0;
            sdata <= shreg[FW-1];
            shreg <= {shreg[FW-2:0], 1'b0};
          end
          S_LO: begin
            st   <= S_HI;
            sclk <= 1'b1;
          end
          S_HI: begin
            if (nbit == BIT_LAST) begin
              st    <= S_LOAD;
              sload <= 1'b1;
            end else begin
              st    <= S_LO;
              nbit  <= nbit + 1'b1;
              sclk  <= 1'b0;
              sdata <= shreg[FW-1];
              shreg <= {shreg[FW-2:0], 1'b0};
            end
          end
          S_LOAD: begin
            st    <= S_IDLE;
            sdata <= 1'b1;
            sclk  <= 1'b1;
            done  <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  // R3
  accept_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!sdata && !sclk && !sload && $past(start)));

  // R4
  data_moves_clk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(sdata)) |-> !sclk);

  // R5
  load_with_clk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload) |-> (sclk && busy));

  // R6
  done_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && sdata && sclk && sload && $past(busy)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $past(st) != S_PRE) |-> (st != S_PRE));

  // R8
  idle_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sdata && sclk));

endmodule

// File: tb/codec_word_tx_test.sv
module codec_word_tx_test;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [8:0] reg_val = '0;
  logic       busy, done, sdata, sclk, sload;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  codec_word_tx #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .reg_addr(reg_addr), .reg_val(reg_val),
    .busy(busy), .done(done), .sdata(sdata), .sclk(sclk), .sload(sload)
  );

  function automatic logic [15:0] pack_word(input logic [6:0] a, input logic [8:0] v);
    return {a, v};
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_frame(input logic [6:0] a, input logic [8:0] v, input bit poke);
    logic [15:0] expw;
    logic [15:0] got;
    int cyc, rises, t_rise, t_fall, t_load, t_done, bad_hi, bad_lo, first_rise;
    bit prev_clk, prev_load;
    expw = pack_word(a, v);
    got = '0; rises = 0; t_rise = -1; t_fall = -1; t_load = -1; t_done = -1;
    bad_hi = 0; bad_lo = 0; first_rise = -1;
    @(negedge clk);
    start = 1'b1; reg_addr = a; reg_val = v;
    @(negedge clk);
    start = 1'b0;
    // R3 / R9: lines low, busy high one cycle after accept
    chk(busy == 1'b1, "R3", "busy after accept", busy, 1);
    chk({sdata, sclk} == 2'b00, "R3", "data/clk low after accept", {sdata, sclk}, 0);
    chk(sload == 1'b0, "R9", "load low after accept", sload, 0);
    prev_clk = 1'b0; prev_load = 1'b0; cyc = 0;
    while (!done && cyc < 40 * HOLD) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 5) begin
        start = 1'b1; reg_addr = ~a; reg_val = ~v;
      end
      if (poke && cyc == 6) start = 1'b0;
      if (sclk && !prev_clk) begin
        rises++;
        got = {got[14:0], sdata};
        if (first_rise < 0) first_rise = cyc;
        else if (cyc - t_fall != HOLD) bad_lo++;
        t_rise = cyc;
      end
      if (!sclk && prev_clk) begin
        if (cyc - t_rise != HOLD) bad_hi++;
        t_fall = cyc;
      end
      if (sload && !prev_load) t_load = cyc;
      if (done) t_done = cyc;
      prev_clk = sclk; prev_load = sload;
    end
    if (!done) begin
      chk(1'b0, "R6", "frame never finished", cyc, 34 * HOLD);
      return;
    end
    chk(got == expw, poke ? "R7" : "R1", "word shifted out", got, expw);
    chk(rises == 16, "R2", "clock rises", rises, 16);
    chk(first_rise == 2 * HOLD, "R4", "first rise position", first_rise, 2 * HOLD);
    chk(bad_lo == 0 && bad_hi == 0, "R4", "phase length errors", bad_lo + bad_hi, 0);
    chk(t_load == t_rise + HOLD, "R5", "load rise position", t_load, t_rise + HOLD);
    chk(t_done == 34 * HOLD, "R6", "done position", t_done, 34 * HOLD);
    chk({busy, sdata, sclk, sload} == 4'b0111, "R6", "end state", {busy, sdata, sclk, sload}, 7);
    @(negedge clk);
    chk(done == 1'b0, "R6", "done one cycle", done, 0);
    repeat (3) @(negedge clk);
    chk({busy, sdata, sclk, sload} == 4'b0111, "R6", "idle holds lines high", {busy, sdata, sclk, sload}, 7);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk({busy, done, sdata, sclk, sload} == 5'b00110, "R8", "reset state",
        {busy, done, sdata, sclk, sload}, 6);
    run_frame(7'h00, 9'h000, 1'b0);
    run_frame(7'h7F, 9'h1FF, 1'b0);
    run_frame(7'h55, 9'h0AA, 1'b0);
    run_frame(7'h01, 9'h100, 1'b0);
    // R7: start pulse with other operands in mid-frame
    run_frame(7'h2A, 9'h155, 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic [6:0] ra;
      logic [8:0] rv;
      ra = 7'($urandom);
      rv = 9'($urandom);
      run_frame(ra, rv, (i % 4) == 3);
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule